// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Per-Byte Wildcards

The block stores three alarm bytes (hours, minutes, seconds) and checks them against the current time bytes. The check happens only when the timekeeping logic pulses an update strobe, once per update cycle. Any alarm byte whose two top bits are both 1 is a wildcard and counts as a match whatever the time byte holds. Because of this, one comparator can fire once a day, once an hour, once a minute or once a second. The comparison is a plain byte equality, so the alarm bytes must use the same encoding as the time bytes, BCD or binary.

A full match sets a sticky alarm flag and gives a one-cycle hit pulse. An interrupt request is raised while the flag is set and interrupts are enabled. The host clears the flag with a clear pulse, which stands for a read of the flag register.

During battery backup, host writes and flag clears are ignored, but the comparison keeps running so that the alarm can wake the system. The reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `tod_alarm_match`

## Requirements
- R1: While reset is asserted, and after it is released, `alarm_flag`, `alarm_hit` and `irq_req` are 0. All three alarm bytes reset to 8'h00, so a strobe at time 00:00:00 matches.
- R2: No change of the flag or hit outputs happens in a cycle where `upd_stb` is 0, even if the time bytes equal the alarm bytes.
- R3: With no wildcard bytes, a strobe sets the flag only when hours, minutes and seconds all equal their alarm bytes. A difference in any single byte gives no flag.
- R4: An alarm byte with bits [7:6] equal to 2'b11 is a wildcard and matches any time byte. A byte with only bit 7 set (for example 8'h80) is compared literally.
- R5: A strobe with a full match sets `alarm_flag` at that clock edge. The flag is visible in the following cycle and stays 1 until it is cleared.
- R6: `irq_req` is 1 exactly when `alarm_flag` is 1 and `irq_en` is 1, and it follows `irq_en` without a clock delay.
- R7: A `flag_clr` pulse clears the flag at the next edge. If a matching strobe occurs in the same cycle, the flag stays 1 and the new event is kept.
- R8: While `bkup_mode` is 1, `cfg_we` and `flag_clr` have no effect, and strobed comparisons still set the flag.
- R9: `cfg_we` loads `cfg_wdata` into the selected alarm byte at the clock edge. The select codes are 0 for seconds, 1 for minutes and 2 for hours. Code 3 writes nothing.
- R10: `alarm_hit` is 1 for exactly one cycle after each matching strobe. It pulses again on every later matching strobe, whether or not the flag was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bkup_mode | input | 1 | Battery-backup mode; host access ignored |
| cfg_we | input | 1 | Alarm byte write enable |
| cfg_sel | input | 2 | Alarm byte select: 0 sec, 1 min, 2 hr, 3 none |
| cfg_wdata | input | 8 | Alarm byte write data |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| upd_stb | input | 1 | One-cycle update strobe; comparison point |
| flag_clr | input | 1 | Flag clear pulse (flag register read) |
| irq_en | input | 1 | Alarm interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_hit | output | 1 | One-cycle pulse per matching strobe |
| irq_req | output | 1 | Interrupt request |

## Verification
The flag and the hit pulse are registered, so each is due one clock after the edge that samples the strobe, clear or write. A write therefore affects only strobes in later cycles. `irq_req` is combinational and is due in the same cycle as the flag and `irq_en` it depends on. The bench drives each stimulus at a falling edge and queues the expected flag, hit and request. The monitor samples a quarter period after the next rising edge, which is exactly one register delay later, and pops one queued item per cycle.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_F  = 3;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HR   = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/alm_byte_cmp.sv
module alm_byte_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] alm_byte,
  input  logic [W-1:0] cur_byte,
  output logic         byte_ok
);
  logic wild;

  always_comb begin
    wild    = (alm_byte[W-1:W-2] == 2'b11);
    byte_ok = wild || (alm_byte == cur_byte);
  end
endmodule

// File: rtl/alm_store.sv
module alm_store
  import alm_pkg::*;
#(
  parameter int unsigned W = BYTE_W,
  parameter int unsigned N = NUM_F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkup,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wdata,
  output logic [N*W-1:0]   bytes_o
);
  logic host_ok;

  always_comb host_ok = we && !bkup;

  for (genvar i = 0; i < N; i++) begin : g_fld
    logic [W-1:0] b_q, b_d;
    logic         ld;

    always_comb begin
      ld  = host_ok && (sel == SEL_W'(i));
      b_d = ld ? wdata : b_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_q <= '0;
      else        b_q <= b_d;
    end

    assign bytes_o[i*W +: W] = b_q;

    // R9
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !bkup && sel == SEL_W'(i)) |=> (b_q == $past(wdata)));
  end

  // R8
  bkup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkup |=> $stable(bytes_o));
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic bkup,
  input  logic stb,
  input  logic match,
  input  logic clr,
  output logic flag,
  output logic hit
);
  logic flag_q, flag_d, hit_q, hit_d, set_ev, clr_ev;

  always_comb begin
    set_ev = stb && match;
    clr_ev = clr && !bkup;
    hit_d  = set_ev;
    if (set_ev)      flag_d = 1'b1;
    else if (clr_ev) flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      hit_q  <= hit_d;
    end
  end

  assign flag = flag_q;
  assign hit  = hit_q;

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && match) |=> (flag && hit));

  // R2
  no_stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !flag) |=> (!flag && !hit));

  // R7
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !bkup && !(stb && match)) |=> !flag);

  // R8
  bkup_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bkup && flag) |=> flag);

  // R10
  hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> flag);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import alm_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bkup_mode,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [W-1:0]     cfg_wdata,
  input  logic [W-1:0]     cur_sec,
  input  logic [W-1:0]     cur_min,
  input  logic [W-1:0]     cur_hr,
  input  logic             upd_stb,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic             alarm_flag,
  output logic             alarm_hit,
  output logic             irq_req
);
  localparam int unsigned N = NUM_F;

  logic           rst_i_n;
  logic [N*W-1:0] alm_bytes;
  logic [N*W-1:0] cur_bytes;
  logic [N-1:0]   byte_ok;
  logic           all_ok;

  alm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  alm_store #(.W(W), .N(N)) u_store (
    .clk(clk), .rst_n(rst_i_n), .bkup(bkup_mode), .we(cfg_we),
    .sel(cfg_sel), .wdata(cfg_wdata), .bytes_o(alm_bytes)
  );

  assign cur_bytes = {cur_hr, cur_min, cur_sec};

  for (genvar i = 0; i < N; i++) begin : g_cmp
    alm_byte_cmp #(.W(W)) u_cmp (
      .alm_byte(alm_bytes[i*W +: W]),
      .cur_byte(cur_bytes[i*W +: W]),
      .byte_ok (byte_ok[i])
    );
  end

  always_comb all_ok = &byte_ok;

  alm_flag u_flag (
    .clk(clk), .rst_n(rst_i_n), .bkup(bkup_mode), .stb(upd_stb),
    .match(all_ok), .clr(flag_clr), .flag(alarm_flag), .hit(alarm_hit)
  );

  always_comb irq_req = alarm_flag && irq_en;

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!irq_en) |-> !irq_req);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    (!rst_i_n) |-> (!alarm_flag && !alarm_hit));
endmodule

// File: tb/test_tod_alarm_match.sv
module test_tod_alarm_match;
  localparam int CLK_P = 10;

  typedef struct {
    logic  flag;
    logic  hit;
    logic  irq;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bkup_mode, cfg_we, upd_stb, flag_clr, irq_en;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata, cur_sec, cur_min, cur_hr;
  logic       alarm_flag, alarm_hit, irq_req;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t q[$];

  logic [7:0] m_alm[3];
  logic       m_flag;
  logic       g_en, g_bk;

  always #(CLK_P/2) clk = ~clk;

  tod_alarm_match i_tod_alarm_match (
    .clk(clk), .rst_n(rst_n), .bkup_mode(bkup_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hr(cur_hr), .upd_stb(upd_stb),
    .flag_clr(flag_clr), .irq_en(irq_en), .alarm_flag(alarm_flag),
    .alarm_hit(alarm_hit), .irq_req(irq_req)
  );

  function automatic logic ok_byte(logic [7:0] a, logic [7:0] c);
    return (a[7:6] == 2'b11) || (a == c);
  endfunction

  task automatic step(input logic stb, input logic [7:0] h, m, s,
                      input logic clr, input logic we, input logic [1:0] sel,
                      input logic [7:0] wd, input string tag);
    exp_t e;
    logic set;
    @(negedge clk);
    upd_stb = stb; cur_hr = h; cur_min = m; cur_sec = s;
    flag_clr = clr; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    irq_en = g_en; bkup_mode = g_bk;
    set = stb && ok_byte(m_alm[2], h) && ok_byte(m_alm[1], m) && ok_byte(m_alm[0], s);
    if (set)              m_flag = 1'b1;
    else if (clr && !g_bk) m_flag = 1'b0;
    if (we && !g_bk && sel != 2'd3) m_alm[sel] = wd;
    e.flag = m_flag; e.hit = set; e.irq = m_flag && g_en; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic strobe(input logic [7:0] h, m, s, input string tag);
    step(1'b1, h, m, s, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  task automatic clear(input string tag);
    step(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string tag);
    step(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, sel, d, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (alarm_flag !== e.flag || alarm_hit !== e.hit || irq_req !== e.irq) begin
          n_bad++;
          $display("FAIL %s: flag/hit/irq got %b%b%b expected %b%b%b",
                   e.tag, alarm_flag, alarm_hit, irq_req, e.flag, e.hit, e.irq);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_P*20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bkup_mode = 0; cfg_we = 0; upd_stb = 0; flag_clr = 0;
    irq_en = 0; cfg_sel = 0; cfg_wdata = 0; cur_sec = 0; cur_min = 0; cur_hr = 0;
    m_alm[0] = 8'h00; m_alm[1] = 8'h00; m_alm[2] = 8'h00;
    m_flag = 0; g_en = 0; g_bk = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (alarm_flag !== 1'b0 || alarm_hit !== 1'b0 || irq_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: flag/hit/irq got %b%b%b expected 000",
               alarm_flag, alarm_hit, irq_req);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    strobe(8'h00, 8'h00, 8'h00, "R1 reset alarm 00:00:00");
    clear("R7 clear");
    wr(2'd2, 8'h12, "R9 write hr");
    wr(2'd1, 8'h34, "R9 write min");
    wr(2'd0, 8'h56, "R9 write sec");
    wr(2'd3, 8'h00, "R9 sel 3 ignored");
    step(1'b0, 8'h12, 8'h34, 8'h56, 1'b0, 1'b0, 2'd0, 8'h00, "R2 match without strobe");
    strobe(8'h12, 8'h34, 8'h57, "R3 sec differs");
    strobe(8'h12, 8'h35, 8'h56, "R3 min differs");
    strobe(8'h13, 8'h34, 8'h56, "R3 hr differs");
    strobe(8'h12, 8'h34, 8'h56, "R5 full match");
    idle("R5 flag sticky");
    g_en = 1; idle("R6 irq enabled");
    g_en = 0; idle("R6 irq disabled");
    g_en = 1; clear("R7 clear drops flag");
    step(1'b1, 8'h12, 8'h34, 8'h56, 1'b1, 1'b0, 2'd0, 8'h00, "R7 clear with match keeps flag");
    strobe(8'h12, 8'h34, 8'h56, "R10 second hit");
    idle("R10 hit one cycle");
    clear("R7 clear");
    wr(2'd2, 8'hC0, "R9 hr wildcard");
    strobe(8'h07, 8'h34, 8'h56, "R4 hr wildcard match");
    clear("R7 clear");
    strobe(8'h07, 8'h34, 8'h55, "R4 hr wild sec differs");
    wr(2'd2, 8'h80, "R9 hr 80");
    strobe(8'h07, 8'h34, 8'h56, "R4 80 is literal");
    strobe(8'h80, 8'h34, 8'h56, "R4 80 literal match");
    clear("R7 clear");
    wr(2'd1, 8'hC0, "R9 min wild");
    wr(2'd0, 8'hFF, "R9 sec wild");
    wr(2'd2, 8'hC3, "R9 hr wild");
    strobe(8'h23, 8'h59, 8'h01, "R4 all wildcards");
    clear("R7 clear");
    g_bk = 1;
    wr(2'd2, 8'h05, "R8 write in backup ignored");
    strobe(8'h09, 8'h00, 8'h00, "R8 compare in backup");
    clear("R8 clear in backup ignored");
    g_bk = 0;
    clear("R7 clear after backup");
    idle("drain");
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule